// File: doc/BRIEF.md
# Port-Mapped SPI Command Engine

This block is an SPI master that a host drives through a window of eight byte-wide I/O registers. The window sits at a base address that is set on a configuration input. Software fills in an opcode, up to three address bytes and an optional data byte. It then writes a control byte to the first register of the window. The control byte chooses how many bytes go out, how many bytes come back and which serial clock rate is used, and it starts the transfer.

The engine lowers chip select and shifts the selected bytes out most significant bit first in SPI mode 0. It then clocks in up to three response bytes while holding the output line low. The response bytes land in readable registers in the order they arrived. While a transfer runs, the top bit of the first register reads as a busy flag.

The serial clock comes from a divider on the system clock. The divider ratio depends on the rate field of the control byte.

Top module: `pio_spi_cmd`

## Requirements
- R1: The window responds only when `cfg_base` is nonzero, a multiple of 8 and below 0x1000. With any other base, every read returns 0x00 and no write has any effect, including a write that would start a transfer.
- R2: A write to offset 0 whose bits [7:4] are nonzero starts a transfer if the engine is idle. A write whose bits [7:4] are zero starts nothing. A start written while a transfer is running, including one that lands on the transfer's final clock edge, is ignored.
- R3: During a transfer, a read of offset 0 returns 0x80 (bit 7 is busy, bits [6:0] are zero). When the engine is idle, the same read returns 0x00.
- R4: Control bits [1:0] choose what is sent, most significant bit first: 0 sends the opcode (offset 1); 1 sends the opcode and then the data byte (offset 7); 2 sends the opcode and then offsets 4, 3 and 2 in that order; 3 sends the opcode, offsets 4, 3 and 2, and then the data byte.
- R5: Control bits [3:2] give a receive count N from 0 to 3. After the transmit bytes, the engine clocks in 8×N more bits while holding MOSI low. Received byte k (k = 0, 1, 2, in wire order) reads back from offset 5+k. A start clears all three receive registers, so a byte that was not received reads as 0x00.
- R6: Chip select is low exactly while the engine is busy. SCLK idles low. MOSI changes only when SCLK falls or chip select changes, and MISO is sampled on SCLK rising.
- R7: A rate field (bits [7:4]) of 5 selects a half-period of HALF_FAST system clocks (default 3). Any other nonzero rate selects HALF_SLOW (default 6). A transfer of B total bits holds chip select low for (2B+1) half-periods, starting at the clock edge that accepts the start.
- R8: Offsets 1 to 4 read back the last value written to them. A write to offset 7 sets the transmit data byte, but a read of offset 7 returns receive byte 2. Writes to offsets 5 and 6 are ignored.
- R9: After reset, chip select is high, SCLK and MOSI are low, the engine is idle, and all registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 16 | Base I/O address of the register window |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for the register at `io_addr` (0 when not addressed) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Two functions can fall on the same clock edge: a transfer finishing, where busy clears, and a new start write being accepted. The bench times a start write so that it lands on the last edge of a running transfer. The write must be ignored: chip select must rise and stay high, and the device model must see no new frame. A second overlap places a start write in the middle of a running transfer. The bench then confirms that the bit count on the wire and the captured bytes match the first command alone. A per-clock reference model of the chip-select window judges both cases on every cycle.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
// psc_pkg: shared types and frame helpers for the port-mapped SPI engine.
// Assumes byte-wide registers and a transmit frame of at most five bytes.
package psc_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 5;
    localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
    localparam int RX_MAX      = 3;
    localparam int WIN_OFF_W   = 3;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_TAIL
    } phase_t;

    // Number of bytes sent for a transmit code
    function automatic logic [2:0] tx_byte_count(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    // Left-aligned transmit frame; address goes out highest offset first
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [BYTE_W-1:0] op,
        input logic [BYTE_W-1:0] a2,
        input logic [BYTE_W-1:0] a3,
        input logic [BYTE_W-1:0] a4,
        input logic [BYTE_W-1:0] dat,
        input logic [1:0]        code);
        case (code)
            2'd0:    return {op, {4*BYTE_W{1'b0}}};
            2'd1:    return {op, dat, {3*BYTE_W{1'b0}}};
            2'd2:    return {op, a4, a3, a2, {BYTE_W{1'b0}}};
            default: return {op, a4, a3, a2, dat};
        endcase
    endfunction

endpackage

// File: rtl/psc_decode.sv
`timescale 1ns/1ps
// psc_decode: checks the configured base and maps a host address to a
// window offset. Assumes the window is 2**WIN_OFF_W bytes, aligned to its size.
module psc_decode
    import psc_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_LIMIT = 16'h1000
) (
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [ADDR_W-1:0]    io_addr,
    output logic                 sel_valid,
    output logic [WIN_OFF_W-1:0] sel_off
);

    logic base_ok;

    // Base must be nonzero, aligned and below the limit
    always_comb begin
        base_ok = (cfg_base != '0) &&
                  (cfg_base[WIN_OFF_W-1:0] == '0) &&
                  (cfg_base < ADDR_W'(BASE_LIMIT));
    end

    // Address hits when the upper bits match the base
    always_comb begin
        sel_valid = base_ok &&
                    (io_addr[ADDR_W-1:WIN_OFF_W] == cfg_base[ADDR_W-1:WIN_OFF_W]);
        sel_off   = io_addr[WIN_OFF_W-1:0];
    end

endmodule

// File: rtl/psc_regs.sv
`timescale 1ns/1ps
// psc_regs: register window. Holds the opcode, the address bytes, the data
// byte and the receive bytes, and produces the start request and frame.
// Assumes the shifter latches the frame in the cycle the start is accepted.
module psc_regs
    import psc_pkg::*;
#(
    parameter logic [3:0] RATE_FAST = 4'h5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_valid,
    input  logic [WIN_OFF_W-1:0] sel_off,
    input  logic                 io_wr,
    input  logic [BYTE_W-1:0]    io_wdata,
    input  logic                 busy,
    input  logic                 rx_we,
    input  logic [1:0]           rx_idx,
    input  logic [BYTE_W-1:0]    rx_byte,
    output logic [BYTE_W-1:0]    io_rdata,
    output logic                 start,
    output logic                 fast,
    output logic [FRAME_W-1:0]   frame,
    output logic [2:0]           tx_bytes,
    output logic [1:0]           rx_count
);

    logic [BYTE_W-1:0] op_q, a2_q, a3_q, a4_q, dat_q;
    logic [BYTE_W-1:0] rx_q [RX_MAX];
    logic              wr_hit;

    // Qualified write strobe
    always_comb wr_hit = sel_valid && io_wr;

    // Start request and transfer shape taken from the control write
    always_comb begin
        start    = wr_hit && (sel_off == '0) && (io_wdata[7:4] != 4'h0) && !busy;
        fast     = (io_wdata[7:4] == RATE_FAST);
        rx_count = io_wdata[3:2];
        tx_bytes = tx_byte_count(io_wdata[1:0]);
        frame    = build_frame(op_q, a2_q, a3_q, a4_q, dat_q, io_wdata[1:0]);
    end

    // Command register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            a2_q  <= '0;
            a3_q  <= '0;
            a4_q  <= '0;
            dat_q <= '0;
        end else if (wr_hit) begin
            case (sel_off)
                3'd1:    op_q  <= io_wdata;
                3'd2:    a2_q  <= io_wdata;
                3'd3:    a3_q  <= io_wdata;
                3'd4:    a4_q  <= io_wdata;
                3'd7:    dat_q <= io_wdata;
                default: ;
            endcase
        end
    end

    // Receive registers, one per byte position
    for (genvar k = 0; k < RX_MAX; k++) begin : g_rx
        // Clear on start, load when the shifter finishes byte k
        always_ff @(posedge clk) begin
            if (!rst_n || start)
                rx_q[k] <= '0;
            else if (rx_we && (rx_idx == 2'(k)))
                rx_q[k] <= rx_byte;
        end
    end

    // Read mux
    always_comb begin
        io_rdata = '0;
        if (sel_valid) begin
            case (sel_off)
                3'd0:    io_rdata = {busy, 7'b0};
                3'd1:    io_rdata = op_q;
                3'd2:    io_rdata = a2_q;
                3'd3:    io_rdata = a3_q;
                3'd4:    io_rdata = a4_q;
                3'd5:    io_rdata = rx_q[0];
                3'd6:    io_rdata = rx_q[1];
                default: io_rdata = rx_q[2];
            endcase
        end
    end

endmodule

// File: rtl/psc_shifter.sv
`timescale 1ns/1ps
// psc_shifter: SPI mode 0 bit engine. Divides the system clock into
// half-periods, shifts the frame out MSB first and then samples the
// receive bits. Assumes start is only asserted while idle.
module psc_shifter
    import psc_pkg::*;
#(
    parameter int HALF_FAST = 3,
    parameter int HALF_SLOW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               fast,
    input  logic [FRAME_W-1:0] frame,
    input  logic [2:0]         tx_bytes,
    input  logic [1:0]         rx_count,
    input  logic               miso,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic               busy,
    output logic               rx_we,
    output logic [1:0]         rx_idx,
    output logic [BYTE_W-1:0]  rx_byte
);

    localparam int HALF_MAX = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
    localparam int DIV_W    = $clog2(HALF_MAX + 1);
    localparam int BIT_W    = $clog2(FRAME_W + RX_MAX * BYTE_W + 1);
    localparam int RXP_W    = $clog2(RX_MAX * BYTE_W);
    localparam logic [DIV_W-1:0] LAST_FAST = DIV_W'(HALF_FAST - 1);
    localparam logic [DIV_W-1:0] LAST_SLOW = DIV_W'(HALF_SLOW - 1);
    localparam logic [DIV_W-1:0] DIV_ONE   = DIV_W'(1);
    localparam logic [BIT_W-1:0] BIT_ONE   = BIT_W'(1);

    phase_t             phase;
    logic [DIV_W-1:0]   div_cnt, div_last;
    logic [BIT_W-1:0]   bit_cnt, bit_last, tx_bits_q;
    logic [BIT_W-1:0]   tx_bits_n, total_n;
    logic [FRAME_W-1:0] shreg;
    logic [BYTE_W-1:0]  rx_sh;
    logic [RXP_W-1:0]   rxpos;
    logic               half_done;

    // Bit counts for the requested transfer
    always_comb begin
        tx_bits_n = BIT_W'({tx_bytes, 3'b000});
        total_n   = tx_bits_n + BIT_W'({rx_count, 3'b000});
    end

    // Divider end and receive bit position
    always_comb begin
        half_done = (div_cnt == div_last);
        rxpos     = RXP_W'(bit_cnt - tx_bits_q);
    end

    // Serial data out is the frame MSB
    always_comb mosi = shreg[FRAME_W-1];
    always_comb busy = (phase != PH_IDLE);

    // Phase sequencer, divider and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cs_n      <= 1'b1;
            sclk      <= 1'b0;
            div_cnt   <= '0;
            div_last  <= '0;
            bit_cnt   <= '0;
            bit_last  <= '0;
            tx_bits_q <= '0;
            shreg     <= '0;
            rx_sh     <= '0;
            rx_we     <= 1'b0;
            rx_idx    <= '0;
            rx_byte   <= '0;
        end else begin
            rx_we <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_LOW;
                        cs_n      <= 1'b0;
                        sclk      <= 1'b0;
                        shreg     <= frame;
                        div_cnt   <= '0;
                        div_last  <= fast ? LAST_FAST : LAST_SLOW;
                        bit_cnt   <= '0;
                        bit_last  <= total_n - BIT_ONE;
                        tx_bits_q <= tx_bits_n;
                    end
                end
                PH_LOW: begin
                    if (half_done) begin
                        div_cnt <= '0;
                        sclk    <= 1'b1;
                        phase   <= PH_HIGH;
                        if (bit_cnt >= tx_bits_q) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], miso};
                            if (rxpos[2:0] == 3'b111) begin
                                rx_we   <= 1'b1;
                                rx_idx  <= rxpos[RXP_W-1:3];
                                rx_byte <= {rx_sh[BYTE_W-2:0], miso};
                            end
                        end
                    end else begin
                        div_cnt <= div_cnt + DIV_ONE;
                    end
                end
                PH_HIGH: begin
                    if (half_done) begin
                        div_cnt <= '0;
                        sclk    <= 1'b0;
                        if (bit_cnt == bit_last) begin
                            phase <= PH_TAIL;
                        end else begin
                            bit_cnt <= bit_cnt + BIT_ONE;
                            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                            phase   <= PH_LOW;
                        end
                    end else begin
                        div_cnt <= div_cnt + DIV_ONE;
                    end
                end
                default: begin
                    if (half_done) begin
                        cs_n  <= 1'b1;
                        shreg <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        div_cnt <= div_cnt + DIV_ONE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pio_spi_cmd.sv
`timescale 1ns/1ps
// pio_spi_cmd: port-mapped SPI command engine. Eight byte registers at a
// configurable base hold a command; a control write sends it and collects
// up to three response bytes. Assumes one-cycle host write strobes.
module pio_spi_cmd
    import psc_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_LIMIT = 16'h1000,
    parameter logic [3:0]  RATE_FAST  = 4'h5,
    parameter int          HALF_FAST  = 3,
    parameter int          HALF_SLOW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic                 sel_valid;
    logic [WIN_OFF_W-1:0] sel_off;
    logic                 busy, start, fast, rx_we;
    logic [FRAME_W-1:0]   frame;
    logic [2:0]           tx_bytes;
    logic [1:0]           rx_count, rx_idx;
    logic [BYTE_W-1:0]    rx_byte;

    psc_decode #(
        .ADDR_W     (ADDR_W),
        .BASE_LIMIT (BASE_LIMIT)
    ) u_decode (
        .cfg_base  (cfg_base),
        .io_addr   (io_addr),
        .sel_valid (sel_valid),
        .sel_off   (sel_off)
    );

    psc_regs #(
        .RATE_FAST (RATE_FAST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_valid (sel_valid),
        .sel_off   (sel_off),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .busy      (busy),
        .rx_we     (rx_we),
        .rx_idx    (rx_idx),
        .rx_byte   (rx_byte),
        .io_rdata  (io_rdata),
        .start     (start),
        .fast      (fast),
        .frame     (frame),
        .tx_bytes  (tx_bytes),
        .rx_count  (rx_count)
    );

    psc_shifter #(
        .HALF_FAST (HALF_FAST),
        .HALF_SLOW (HALF_SLOW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .fast     (fast),
        .frame    (frame),
        .tx_bytes (tx_bytes),
        .rx_count (rx_count),
        .miso     (spi_miso),
        .cs_n     (spi_cs_n),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .busy     (busy),
        .rx_we    (rx_we),
        .rx_idx   (rx_idx),
        .rx_byte  (rx_byte)
    );

endmodule

// File: rtl/psc_checker.sv
`timescale 1ns/1ps
// psc_checker: protocol and register-window properties for pio_spi_cmd.
// Assumes it is bound into the top so it can observe the busy state.
module psc_checker #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_LIMIT = 16'h1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              spi_cs_n,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic              busy
);

    logic base_ok, ctrl_hit, start_try;

    // Independent view of a legal base and of a control-register access
    always_comb begin
        base_ok   = (cfg_base != '0) && (cfg_base[2:0] == 3'b000) &&
                    (cfg_base < ADDR_W'(BASE_LIMIT));
        ctrl_hit  = base_ok && (io_addr == cfg_base);
        start_try = io_wr && ctrl_hit && (io_wdata[7:4] != 4'h0) && !busy;
    end

    assert_window_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !base_ok |-> (io_rdata == 8'h00));

    assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(start_try));

    assert_busy_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && busy) |-> (io_rdata == 8'h80));

    assert_cs_tracks_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n == !busy);

    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> ($fell(spi_sclk) || $fell(spi_cs_n) || $rose(spi_cs_n)));

endmodule

bind pio_spi_cmd psc_checker #(
    .ADDR_W     (ADDR_W),
    .BASE_LIMIT (BASE_LIMIT)
) u_psc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_base (cfg_base),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .busy     (busy)
);

// File: tb/tb_pio_spi_cmd.sv
`timescale 1ns/1ps
// tb_pio_spi_cmd: behavioural reference for the chip-select window, a
// device model on the SPI pins, and directed command sequences.
module tb_pio_spi_cmd;

    localparam int HF = 3;
    localparam int HS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_base = 16'h0300;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    pio_spi_cmd dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .io_addr(io_addr),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [63:0] sl_stream = '0;
    logic [63:0] sl_cap = '0;
    int          sl_idx = 0;

    always @(negedge spi_cs_n) begin
        sl_idx   = 0;
        sl_cap   = '0;
        spi_miso = sl_stream[63];
    end
    always @(posedge spi_sclk) begin
        if (!spi_cs_n && sl_idx < 64) begin
            sl_cap[63 - sl_idx] = spi_mosi;
            sl_idx++;
        end
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n && sl_idx < 64) spi_miso = sl_stream[63 - sl_idx];
    end

    // ---------------- reference model of the transfer window ----------------
    int mdl_cnt = 0;

    function automatic bit base_legal(input logic [15:0] b);
        return (b != 0) && (b[2:0] == 0) && (b < 16'h1000);
    endfunction

    function automatic int tx_len(input logic [1:0] code);
        case (code)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic int window_len(input logic [7:0] c);
        int half = (c[7:4] == 4'h5) ? HF : HS;
        int nb = (tx_len(c[1:0]) + int'(c[3:2])) * 8;
        return (2 * nb + 1) * half;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) mdl_cnt = 0;
        else if (mdl_cnt != 0) mdl_cnt--;
        else if (io_wr && base_legal(cfg_base) && io_addr == cfg_base && io_wdata[7:4] != 0)
            mdl_cnt = window_len(io_wdata);
    end

    // R7 / R6: chip select compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk(spi_cs_n == (mdl_cnt == 0), "R7 cs window", 64'(spi_cs_n), 64'(mdl_cnt == 0));
            if (spi_cs_n && spi_sclk) chk(1'b0, "R6 sclk idle", 1, 0);
        end
    end

    // ---------------- host access tasks ----------------
    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        #1 d = io_rdata;
    endtask

    task automatic wait_idle();
        while (mdl_cnt != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [39:0] exp_frame(input logic [7:0] op, a2, a3, a4, dat, input logic [1:0] code);
        case (code)
            2'd0: return {op, 32'h0};
            2'd1: return {op, dat, 24'h0};
            2'd2: return {op, a4, a3, a2, 8'h0};
            default: return {op, a4, a3, a2, dat};
        endcase
    endfunction

    task automatic run_xfer(input logic [7:0] op, a2, a3, a4, dat, input logic [1:0] code,
                            input logic [1:0] rx, input bit fast, input logic [63:0] stream,
                            input bit poke);
        logic [7:0]  r;
        logic [63:0] exp_bits, mask;
        int          nt, nb;
        nt = tx_len(code) * 8;
        nb = nt + int'(rx) * 8;
        io_write(cfg_base + 1, op);
        io_write(cfg_base + 2, a2);
        io_write(cfg_base + 3, a3);
        io_write(cfg_base + 4, a4);
        io_write(cfg_base + 7, dat);
        sl_stream = stream;
        io_write(cfg_base, {fast ? 4'h5 : 4'h4, rx, code});
        io_read(cfg_base, r);
        chk(r == 8'h80, "R3 busy read", 64'(r), 64'h80);
        if (poke) io_write(cfg_base, 8'h5F);   // R2: start while busy
        wait_idle();
        io_read(cfg_base, r);
        chk(r == 8'h00, "R3 idle read", 64'(r), 64'h0);
        chk(sl_idx == nb, "R7 bit count", 64'(sl_idx), 64'(nb));
        exp_bits = {exp_frame(op, a2, a3, a4, dat, code), 24'h0};
        mask = ~64'h0 << (64 - nb);
        chk((sl_cap & mask) == (exp_bits & mask), "R4 mosi frame", sl_cap & mask, exp_bits & mask);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] e;
            e = (k < int'(rx)) ? stream[63 - nt - 8*k -: 8] : 8'h00;
            io_read(cfg_base + 16'(5 + k), r);
            chk(r == e, "R5 rx byte", 64'(r), 64'(e));
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk(spi_cs_n == 1 && spi_sclk == 0 && spi_mosi == 0, "R9 pins", {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
        for (int k = 0; k < 8; k++) begin
            io_read(cfg_base + 16'(k), r);
            chk(r == 0, "R9 reg zero", 64'(r), 0);
        end

        // R8 readback, ignored writes
        io_write(cfg_base + 1, 8'h3C);
        io_write(cfg_base + 4, 8'hC3);
        io_read(cfg_base + 1, r);  chk(r == 8'h3C, "R8 op readback", 64'(r), 64'h3C);
        io_read(cfg_base + 4, r);  chk(r == 8'hC3, "R8 a4 readback", 64'(r), 64'hC3);
        io_write(cfg_base + 5, 8'h77);
        io_write(cfg_base + 7, 8'hA5);
        io_read(cfg_base + 5, r);  chk(r == 8'h00, "R8 rx5 write ignored", 64'(r), 0);
        io_read(cfg_base + 7, r);  chk(r == 8'h00, "R8 offset7 reads rx", 64'(r), 0);

        // R4/R5/R7 transfers over all codes, counts and rates
        run_xfer(8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 2'd3, 1'b1, 64'h00C2_2817_5A00_0000, 1'b0);
        run_xfer(8'h01, 8'h00, 8'h00, 8'h00, 8'h5A, 2'd1, 2'd0, 1'b0, 64'h0, 1'b0);
        run_xfer(8'h20, 8'h34, 8'h12, 8'h81, 8'h00, 2'd2, 2'd0, 1'b1, 64'h0, 1'b0);
        run_xfer(8'h02, 8'hEF, 8'hBE, 8'hAD, 8'h96, 2'd3, 2'd2, 1'b0, 64'hFFFF_FFFF_FF69_F000, 1'b0);
        run_xfer(8'h03, 8'h10, 8'h20, 8'h30, 8'h00, 2'd2, 2'd3, 1'b0, 64'h0000_0000_A55A_C300, 1'b0);
        // R5: fewer bytes received afterwards -> others cleared
        run_xfer(8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 2'd1, 1'b1, 64'h00E7_0000_0000_0000, 1'b0);
        // R2: start written mid-transfer is ignored
        run_xfer(8'hAB, 8'h44, 8'h55, 8'h66, 8'h00, 2'd2, 2'd1, 1'b1, 64'h0000_0000_3D00_0000, 1'b1);

        // R2: rate field zero starts nothing
        io_write(cfg_base, 8'h0F);
        repeat (10) @(negedge clk);
        chk(spi_cs_n == 1, "R2 rate zero no start", 64'(spi_cs_n), 1);

        // R2: start landing on the final edge of a transfer is ignored
        io_write(cfg_base + 1, 8'h66);
        io_write(cfg_base, 8'h50);
        while (mdl_cnt != 1) @(negedge clk);
        io_addr = cfg_base; io_wdata = 8'h50; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk(spi_cs_n == 1, "R2 final-edge start ignored", 64'(spi_cs_n), 1);
        chk(sl_idx == 8, "R2 no new frame", 64'(sl_idx), 8);

        // R1: illegal bases keep the window dark
        cfg_base = 16'h1000;
        io_write(16'h1000, 8'h50);
        repeat (10) @(negedge clk);
        chk(spi_cs_n == 1, "R1 base 0x1000 no start", 64'(spi_cs_n), 1);
        io_read(16'h1001, r); chk(r == 0, "R1 base 0x1000 dark", 64'(r), 0);
        cfg_base = 16'h0304;
        io_write(16'h0304, 8'h50);
        io_read(16'h0305, r); chk(r == 0, "R1 unaligned dark", 64'(r), 0);
        chk(spi_cs_n == 1, "R1 unaligned no start", 64'(spi_cs_n), 1);
        cfg_base = 16'h0000;
        io_write(16'h0000, 8'h50);
        io_read(16'h0001, r); chk(r == 0, "R1 zero base dark", 64'(r), 0);
        chk(spi_cs_n == 1, "R1 zero base no start", 64'(spi_cs_n), 1);

        // R1: highest legal base works
        cfg_base = 16'h0FF8;
        run_xfer(8'h4B, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 2'd1, 1'b0, 64'h0081_0000_0000_0000, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule